// File: doc/BRIEF.md
# Digitizer event packet assembler

This block builds one readout event from per-channel waveform samples and sends it as a stream of 16-bit words over a valid/ready output. An event starts when a trigger descriptor is accepted. The descriptor carries the event ID, the channel enable mask, the region-of-interest size and the timestamp. From it the block writes a fixed 18-word header. The header holds identification and status fields, a computed packet length and a folded device identifier. One block then follows for each enabled channel. A stop-cell word, a packet CRC32 and a tail marker close the packet.

Samples come from an external source that takes a channel index and returns one word per handshake. Each channel block holds its channel ID word, the sample words and its own CRC32. The status, identification and software-written fields are plain inputs, read while their words go out. Backpressure on the output stalls the whole packet, and no word is lost.

Top module: `digi_event_framer`

## Requirements
- R1: The first word of every packet is 0xAAAA and the last word is 0x5555.
- R2: Header word 1 is the status word. Bit 0 is 1 when the channel mask is all zero. Bit 1 is busyLost, bit 2 is lockNow, bit 3 is lockSec, and bits 15:4 are fpgaTemp.
- R3: Header word 2 is the total packet length in 16-bit words, equal to 22 + n*(roi+3), where n is the number of enabled channels. Header word 3 is the ROI size, in samples per channel.
- R4: Header word 4 is deviceDna[63:48] ^ deviceDna[47:32] ^ deviceDna[31:16] ^ deviceDna[15:0].
- R5: Header word 9 has boardId in bits 15:8, zero in bits 7:6 and linkId in bits 5:0. Header word 10 has the channel mask in bits 8:0 and zero in bits 15:9.
- R6: The other header words, by index, are these:
  - 5: zero.
  - 6 and 7: hkWord, upper half first.
  - 8: fwHash.
  - 11 and 12: the event ID, upper half first.
  - 13: dtapWord.
  - 14: drsTemp.
  - 15, 16 and 17: the 48-bit timestamp, most significant word first.
- R7: Only enabled channels emit a block, in ascending channel order. A block is the channel index word followed by ROI sample words, which are passed through unchanged. While the samples of a channel are fetched, smpChan shows that channel.
- R8: Each channel block ends with two words holding the CRC32 of its channel index word and sample words, upper half first. The CRC uses polynomial 0x04C11DB7 and starts at 0xFFFFFFFF. Each word is shifted in MSB first, with no reflection and no final inversion.
- R9: After the channel blocks come the stopCell word and then the packet CRC32, upper half first. The packet CRC uses the same rule as R8 and covers every word from the 0xAAAA word through the stop-cell word.
- R10: While outValid is high and outReady is low, outValid stays high and outData holds its value. No word is dropped or repeated.
- R11: evReady is high only when no packet is in progress. It is high after reset, low from acceptance until the tail word is taken, and high again in the next cycle. With a ROI of 0, each enabled channel block has 3 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Trigger descriptor offered |
| evReady | output | 1 | Descriptor accepted (idle) |
| evId | input | 32 | Event ID from the trigger |
| evChMask | input | 9 | Channel enable mask |
| evTimestamp | input | 48 | Clock ticks since the last resync |
| roiWords | input | 16 | Samples per channel |
| busyLost | input | 1 | Trigger lost while the digitizer was busy |
| lockNow | input | 1 | Current lock flag |
| lockSec | input | 1 | Lock held over the past second |
| fpgaTemp | input | 12 | FPGA temperature |
| deviceDna | input | 64 | Device identifier |
| hkWord | input | 32 | Software-written housekeeping word |
| fwHash | input | 16 | Firmware revision hash |
| boardId | input | 8 | Board identifier |
| linkId | input | 6 | Trigger link identifier |
| dtapWord | input | 16 | Reference tap frequency |
| drsTemp | input | 16 | Digitizer temperature (software-written) |
| stopCell | input | 16 | Digitizer stop cell |
| smpValid | input | 1 | Sample word offered |
| smpReady | output | 1 | Sample word taken |
| smpChan | output | 4 | Channel whose samples are requested |
| smpData | input | 16 | Sample word |
| outValid | output | 1 | Output word valid |
| outReady | input | 1 | Output word accepted |
| outData | output | 16 | Output word |

## Verification
Directed events cover four masks: an empty mask, a full mask, a single channel at the top index, and a sparse mask with a ROI of zero. They separate the empty flag and the skip straight to the trailer from the channel-order and block-length logic. Random events then vary the mask, the ROI, every field and the status bits. Three output-ready densities are used, together with a sample source that sometimes withholds data. These show whether the CRCs, the length and the stall hold stay right when a handshake stops in the middle of a block. The sample values follow a running sequence number across the event, so a sample that is skipped, repeated or sent to the wrong channel shows up as a word mismatch.

// File: rtl/digi_pkt_pkg.sv
package digi_pkt_pkg;

  localparam int HDR_WORDS = 18;
  localparam int TRL_WORDS = 4;
  localparam int CH_OVH    = 3;
  localparam logic [15:0] HEAD_MARK = 16'hAAAA;
  localparam logic [15:0] TAIL_MARK = 16'h5555;
  localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
  localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;

  typedef enum logic [2:0] {
    K_IDLE, K_HDR, K_CHID, K_DATA, K_CCRC, K_STOP, K_PCRC, K_TAIL
  } wordKind_t;

  typedef struct packed {
    wordKind_t   kind;
    logic [4:0]  idx;
    logic [3:0]  chan;
    logic        start;
    logic        fire;
  } pktStrobe_t;

  function automatic logic [31:0] crcStep16(input logic [31:0] crcIn, input logic [15:0] w);
    logic [31:0] c;
    logic        fb;
    c = crcIn;
    for (int b = 15; b >= 0; b--) begin
      fb = c[31] ^ w[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/digi_pkt_ctrl.sv
module digi_pkt_ctrl
  import digi_pkt_pkg::*;
#(
  parameter int NUM_CH = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [NUM_CH-1:0] evChMask,
  input  logic [15:0]       roiWords,
  input  logic              smpValid,
  input  logic              outReady,
  output logic              evReady,
  output logic              smpReady,
  output logic              outValid,
  output pktStrobe_t        strobe
);

  localparam logic [4:0] HDR_LAST = 5'(HDR_WORDS - 1);

  wordKind_t         kind;
  logic [4:0]        idx;
  logic [15:0]       cnt;
  logic [15:0]       roiR;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] pendAfter;
  logic [3:0]        curChan;
  logic              fire;
  logic              start;

  always_comb begin
    curChan = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) curChan = 4'(i);
    end
    pendAfter = pending;
    pendAfter[curChan] = 1'b0;
  end

  assign evReady  = (kind == K_IDLE);
  assign start    = evReady && evValid;
  assign outValid = (kind != K_IDLE) && ((kind != K_DATA) || smpValid);
  assign smpReady = (kind == K_DATA) && outReady;
  assign fire     = outValid && outReady;

  assign strobe.kind  = kind;
  assign strobe.idx   = idx;
  assign strobe.chan  = curChan;
  assign strobe.start = start;
  assign strobe.fire  = fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind    <= K_IDLE;
      idx     <= '0;
      cnt     <= '0;
      roiR    <= '0;
      pending <= '0;
    end else if (start) begin
      kind    <= K_HDR;
      idx     <= '0;
      roiR    <= roiWords;
      pending <= evChMask;
    end else if (fire) begin
      unique case (kind)
        K_HDR: begin
          if (idx == HDR_LAST) begin
            kind <= (pending != '0) ? K_CHID : K_STOP;
            idx  <= '0;
          end else begin
            idx <= idx + 5'd1;
          end
        end
        K_CHID: begin
          cnt  <= '0;
          idx  <= '0;
          kind <= (roiR != '0) ? K_DATA : K_CCRC;
        end
        K_DATA: begin
          if (cnt == roiR - 16'd1) begin
            kind <= K_CCRC;
            idx  <= '0;
          end else begin
            cnt <= cnt + 16'd1;
          end
        end
        K_CCRC: begin
          if (idx == 5'd0) begin
            idx <= 5'd1;
          end else begin
            pending <= pendAfter;
            idx     <= '0;
            kind    <= (pendAfter != '0) ? K_CHID : K_STOP;
          end
        end
        K_STOP: begin
          kind <= K_PCRC;
          idx  <= '0;
        end
        K_PCRC: begin
          if (idx == 5'd0) idx <= 5'd1;
          else kind <= K_TAIL;
        end
        K_TAIL:  kind <= K_IDLE;
        default: kind <= K_IDLE;
      endcase
    end
  end

  // R10: a stalled word keeps the sequencer frozen
  assert_stall_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(kind) && $stable(idx) && $stable(pending)));

  // R11: the cycle after the tail is taken the block accepts again
  assert_tail_release_R11: assert property (@(posedge clk) disable iff (!rstN)
    (fire && kind == K_TAIL) |=> evReady);

  // R7: channels are only retired, never added, during a packet
  assert_pending_shrinks_R7: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ((pending & ~$past(pending)) == '0));

endmodule

// File: rtl/digi_pkt_dp.sv
module digi_pkt_dp
  import digi_pkt_pkg::*;
#(
  parameter int NUM_CH = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  pktStrobe_t        strobe,
  input  logic [31:0]       evId,
  input  logic [NUM_CH-1:0] evChMask,
  input  logic [47:0]       evTimestamp,
  input  logic [15:0]       roiWords,
  input  logic              busyLost,
  input  logic              lockNow,
  input  logic              lockSec,
  input  logic [11:0]       fpgaTemp,
  input  logic [63:0]       deviceDna,
  input  logic [31:0]       hkWord,
  input  logic [15:0]       fwHash,
  input  logic [7:0]        boardId,
  input  logic [5:0]        linkId,
  input  logic [15:0]       dtapWord,
  input  logic [15:0]       drsTemp,
  input  logic [15:0]       stopCell,
  input  logic [15:0]       smpData,
  output logic [15:0]       outData
);

  logic [31:0]       evIdR;
  logic [47:0]       tsR;
  logic [NUM_CH-1:0] maskR;
  logic [15:0]       roiR;
  logic [31:0]       chCrc;
  logic [31:0]       pktCrc;
  logic [15:0]       hdrWord;
  logic [15:0]       lenWord;
  logic [15:0]       nEn;
  logic              inChan;
  logic              inPkt;

  assign nEn     = 16'($countones(maskR));
  assign lenWord = 16'(HDR_WORDS + TRL_WORDS) + nEn * (roiR + 16'(CH_OVH));
  assign inChan  = (strobe.kind == K_CHID) || (strobe.kind == K_DATA);
  assign inPkt   = (strobe.kind != K_PCRC) && (strobe.kind != K_TAIL) && (strobe.kind != K_IDLE);

  always_comb begin
    unique case (strobe.idx)
      5'd0:    hdrWord = HEAD_MARK;
      5'd1:    hdrWord = {fpgaTemp, lockSec, lockNow, busyLost, (maskR == '0)};
      5'd2:    hdrWord = lenWord;
      5'd3:    hdrWord = roiR;
      5'd4:    hdrWord = deviceDna[63:48] ^ deviceDna[47:32] ^ deviceDna[31:16] ^ deviceDna[15:0];
      5'd6:    hdrWord = hkWord[31:16];
      5'd7:    hdrWord = hkWord[15:0];
      5'd8:    hdrWord = fwHash;
      5'd9:    hdrWord = {boardId, 2'b00, linkId};
      5'd10:   hdrWord = 16'(maskR);
      5'd11:   hdrWord = evIdR[31:16];
      5'd12:   hdrWord = evIdR[15:0];
      5'd13:   hdrWord = dtapWord;
      5'd14:   hdrWord = drsTemp;
      5'd15:   hdrWord = tsR[47:32];
      5'd16:   hdrWord = tsR[31:16];
      5'd17:   hdrWord = tsR[15:0];
      default: hdrWord = 16'h0000;
    endcase
  end

  always_comb begin
    unique case (strobe.kind)
      K_HDR:   outData = hdrWord;
      K_CHID:  outData = 16'(strobe.chan);
      K_DATA:  outData = smpData;
      K_CCRC:  outData = strobe.idx[0] ? chCrc[15:0] : chCrc[31:16];
      K_STOP:  outData = stopCell;
      K_PCRC:  outData = strobe.idx[0] ? pktCrc[15:0] : pktCrc[31:16];
      K_TAIL:  outData = TAIL_MARK;
      default: outData = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evIdR  <= '0;
      tsR    <= '0;
      maskR  <= '0;
      roiR   <= '0;
      chCrc  <= CRC_INIT;
      pktCrc <= CRC_INIT;
    end else if (strobe.start) begin
      evIdR  <= evId;
      tsR    <= evTimestamp;
      maskR  <= evChMask;
      roiR   <= roiWords;
      chCrc  <= CRC_INIT;
      pktCrc <= CRC_INIT;
    end else if (strobe.fire) begin
      if (inPkt) pktCrc <= crcStep16(pktCrc, outData);
      if (inChan) chCrc <= crcStep16(chCrc, outData);
      else if (strobe.kind == K_CCRC && strobe.idx[0]) chCrc <= CRC_INIT;
    end
  end

  // R9: the packet CRC is frozen while its two words are sent
  assert_pcrc_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.kind == K_PCRC && !strobe.idx[0]) |=> $stable(pktCrc));

  // R8: a channel CRC starts each block from the initial value
  assert_chcrc_fresh_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.kind == K_CCRC && strobe.idx[0]) |=> (chCrc == CRC_INIT));

endmodule

// File: rtl/digi_event_framer.sv
module digi_event_framer
  import digi_pkt_pkg::*;
#(
  parameter int NUM_CH = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  output logic              evReady,
  input  logic [31:0]       evId,
  input  logic [NUM_CH-1:0] evChMask,
  input  logic [47:0]       evTimestamp,
  input  logic [15:0]       roiWords,
  input  logic              busyLost,
  input  logic              lockNow,
  input  logic              lockSec,
  input  logic [11:0]       fpgaTemp,
  input  logic [63:0]       deviceDna,
  input  logic [31:0]       hkWord,
  input  logic [15:0]       fwHash,
  input  logic [7:0]        boardId,
  input  logic [5:0]        linkId,
  input  logic [15:0]       dtapWord,
  input  logic [15:0]       drsTemp,
  input  logic [15:0]       stopCell,
  input  logic              smpValid,
  output logic              smpReady,
  output logic [3:0]        smpChan,
  input  logic [15:0]       smpData,
  output logic              outValid,
  input  logic              outReady,
  output logic [15:0]       outData
);

  pktStrobe_t strobe;

  digi_pkt_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evChMask(evChMask),
    .roiWords(roiWords), .smpValid(smpValid), .outReady(outReady),
    .evReady(evReady), .smpReady(smpReady), .outValid(outValid), .strobe(strobe)
  );

  digi_pkt_dp #(.NUM_CH(NUM_CH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .evId(evId), .evChMask(evChMask),
    .evTimestamp(evTimestamp), .roiWords(roiWords), .busyLost(busyLost),
    .lockNow(lockNow), .lockSec(lockSec), .fpgaTemp(fpgaTemp), .deviceDna(deviceDna),
    .hkWord(hkWord), .fwHash(fwHash), .boardId(boardId), .linkId(linkId),
    .dtapWord(dtapWord), .drsTemp(drsTemp), .stopCell(stopCell), .smpData(smpData),
    .outData(outData)
  );

  assign smpChan = strobe.chan;

  // R1: the opening word is the head marker
  assert_head_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.kind == K_HDR && strobe.idx == 5'd0) |-> (outData == HEAD_MARK));

  // R1: the closing word is the tail marker
  assert_tail_mark_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fire && strobe.kind == K_TAIL) |-> (outData == TAIL_MARK));

  // R7: samples are only taken when the output takes them too
  assert_sample_passthru_R7: assert property (@(posedge clk) disable iff (!rstN)
    (smpValid && smpReady) |-> (outValid && outReady && outData == smpData));

endmodule

// File: tb/digi_event_framer_tb.sv
module digi_event_framer_tb_top;

  localparam int NCH = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evValid = 1'b0;
  logic evReady;
  logic [31:0] evId = '0;
  logic [NCH-1:0] evChMask = '0;
  logic [47:0] evTimestamp = '0;
  logic [15:0] roiWords = '0;
  logic busyLost = 1'b0, lockNow = 1'b0, lockSec = 1'b0;
  logic [11:0] fpgaTemp = '0;
  logic [63:0] deviceDna = '0;
  logic [31:0] hkWord = '0;
  logic [15:0] fwHash = '0, dtapWord = '0, drsTemp = '0, stopCell = '0;
  logic [7:0] boardId = '0;
  logic [5:0] linkId = '0;
  logic smpValid = 1'b0;
  logic smpReady;
  logic [3:0] smpChan;
  logic [15:0] smpData = '0;
  logic outValid;
  logic outReady = 1'b0;
  logic [15:0] outData;

  digi_event_framer #(.NUM_CH(NCH)) dut_i (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  int cycles = 0;
  int evNum = 0;
  int seq = 0;
  int readyMode = 0;
  int gotCnt = 0;
  logic [15:0] got [0:255];
  logic [15:0] expW [0:255];
  string expTag [0:255];
  int expLen = 0;
  bit accepted = 0, busyFlag = 0;
  int busyViol = 0, stallViol = 0, chanViol = 0;
  bit prevStall = 0;
  logic [15:0] prevData = '0;
  logic [15:0] curChanExp = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crcW(input logic [31:0] c, input logic [15:0] w);
    logic [31:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      if (r[31] ^ w[b]) r = (r << 1) ^ 32'h04C11DB7;
      else r = r << 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] sampleVal(input int ev, input int s);
    logic [31:0] v = (ev * 32'h3C5) ^ (s * 32'h9E37) ^ 32'h1234;
    return v[15:0];
  endfunction

  task automatic push(input logic [15:0] w, input string tag);
    expW[expLen] = w;
    expTag[expLen] = tag;
    expLen++;
  endtask

  task automatic buildExpected();
    logic [31:0] pc, cc;
    int n = 0, s = 0;
    expLen = 0;
    for (int c = 0; c < NCH; c++) if (evChMask[c]) n++;
    push(16'hAAAA, "R1 head");
    push({fpgaTemp, lockSec, lockNow, busyLost, (evChMask == '0)}, "R2 status");
    push(16'(22 + n * (roiWords + 3)), "R3 length");
    push(roiWords, "R3 roi");
    push(deviceDna[15:0] ^ deviceDna[31:16] ^ deviceDna[47:32] ^ deviceDna[63:48], "R4 dna");
    push(16'h0000, "R6 reserved");
    push(hkWord[31:16], "R6 hk hi");
    push(hkWord[15:0], "R6 hk lo");
    push(fwHash, "R6 hash");
    push({boardId, 2'b00, linkId}, "R5 id");
    push(16'(evChMask), "R5 mask");
    push(evId[31:16], "R6 event hi");
    push(evId[15:0], "R6 event lo");
    push(dtapWord, "R6 dtap");
    push(drsTemp, "R6 drs temp");
    push(evTimestamp[47:32], "R6 ts hi");
    push(evTimestamp[31:16], "R6 ts mid");
    push(evTimestamp[15:0], "R6 ts lo");
    for (int c = 0; c < NCH; c++) begin
      if (evChMask[c]) begin
        cc = 32'hFFFFFFFF;
        push(16'(c), "R7 chan id");
        cc = crcW(cc, 16'(c));
        for (int k = 0; k < int'(roiWords); k++) begin
          push(sampleVal(evNum, s), "R7 sample");
          cc = crcW(cc, sampleVal(evNum, s));
          s++;
        end
        push(cc[31:16], "R8 chan crc hi");
        push(cc[15:0], "R8 chan crc lo");
      end
    end
    push(stopCell, "R9 stop cell");
    pc = 32'hFFFFFFFF;
    for (int i = 0; i < expLen; i++) pc = crcW(pc, expW[i]);
    push(pc[31:16], "R9 pkt crc hi");
    push(pc[15:0], "R9 pkt crc lo");
    push(16'h5555, "R1 tail");
  endtask

  // per-cycle driver and monitor
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
      case (readyMode)
        0: outReady = 1'b1;
        1: outReady = ($urandom % 4) != 0;
        default: outReady = ($urandom % 10) < 3;
      endcase
      if (!(smpValid && !smpReady)) smpValid = ($urandom % 5) != 0;
      smpData = sampleVal(evNum, seq);
      #1;
      if (prevStall && (!outValid || outData != prevData)) stallViol++;
      prevStall = outValid && !outReady;
      prevData = outData;
      if (busyFlag && evReady) busyViol++;
      if (smpValid && smpReady) begin
        if (16'(smpChan) != curChanExp) chanViol++;
        seq++;
      end
      if (outValid && outReady) begin
        if (gotCnt < 256) got[gotCnt] = outData;
        if (expTag[gotCnt] == "R7 chan id") curChanExp = outData;
        gotCnt++;
      end
      if (evValid && evReady) accepted = 1;
    end
  end

  task automatic runEvent(input logic [NCH-1:0] mask, input logic [15:0] roi, input int mode);
    @(negedge clk);
    evNum++;
    seq = 0;
    gotCnt = 0;
    readyMode = mode;
    evChMask = mask;
    roiWords = roi;
    evId = $urandom;
    evTimestamp = {16'($urandom), 32'($urandom)};
    busyLost = 1'($urandom); lockNow = 1'($urandom); lockSec = 1'($urandom);
    fpgaTemp = 12'($urandom);
    deviceDna = {32'($urandom), 32'($urandom)};
    hkWord = $urandom; fwHash = 16'($urandom); dtapWord = 16'($urandom);
    drsTemp = 16'($urandom); stopCell = 16'($urandom);
    boardId = 8'($urandom); linkId = 6'($urandom);
    buildExpected();
    busyViol = 0; stallViol = 0; chanViol = 0;
    accepted = 0;
    evValid = 1'b1;
    while (!accepted) @(negedge clk);
    evValid = 1'b0;
    busyFlag = 1;
    while (gotCnt < expLen) @(negedge clk);
    busyFlag = 0;
    repeat (6) @(negedge clk);
    check(gotCnt == expLen, "R11 word count", 32'(gotCnt), 32'(expLen));
    for (int i = 0; i < expLen; i++)
      check(got[i] == expW[i], expTag[i], 32'(got[i]), 32'(expW[i]));
    check(busyViol == 0, "R11 evReady low while busy", 32'(busyViol), 0);
    check(evReady == 1'b1, "R11 evReady after tail", 32'(evReady), 1);
    check(stallViol == 0, "R10 stall hold", 32'(stallViol), 0);
    check(chanViol == 0, "R7 smpChan during samples", 32'(chanViol), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(evReady == 1'b1, "R11 reset evReady", 32'(evReady), 1);
    check(outValid == 1'b0, "R11 reset outValid", 32'(outValid), 0);
    check(smpReady == 1'b0, "R11 reset smpReady", 32'(smpReady), 0);
    rstN = 1'b1;
    runEvent(9'h000, 16'd4, 0);
    runEvent(9'h1FF, 16'd4, 1);
    runEvent(9'h100, 16'd8, 2);
    runEvent(9'h0A5, 16'd0, 1);
    runEvent(9'h001, 16'd1, 0);
    for (int e = 0; e < 14; e++)
      runEvent(9'($urandom), 16'($urandom % 9), e % 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule